// File: doc/BRIEF.md
# Alternating Two-Engine Outer Loop Sequencer

This block drives an outer loop of fixed length. In each iteration it starts one of two external inner-loop engines and then waits for that engine to report done. A one-bit selector picks the engine. The selector comes up as 1 at the start of a run, so engine A goes first, and it is inverted at the end of every iteration. After the last iteration the block raises a completion output.

The controller has no encoded state register. Its control stages form a short chain, and each stage is armed by a one-bit predicate register:

- The entry stage is armed by an accepted start.
- The loop-head stage is enabled by the OR of the entry predicate and the predicate coming back from the tail.
- The head either sends its enable to the exit stage or hands it to the engine-select stage.
- The select stage emits the start pulse and arms a wait predicate.
- The wait predicate holds until the running engine reports done. That fires the tail, which toggles the selector, counts the iteration and returns the enable to the head.

Each hand-off between stages takes exactly one clock.

Top module: `alt_loop_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `eng_a_start_o`, `eng_b_start_o` and `finished_o` are 0.
- R2: A `start_i` sampled high while idle produces an `eng_a_start_o` pulse that is visible after the third rising edge, counting the sampling edge as the first. The pulse is not visible after the second edge.
- R3: Each engine start pulse lasts exactly one cycle, and the two start outputs are never high together.
- R4: With the selector initialised to 1 (1 = engine A, 0 = engine B) and inverted after every iteration, iterations 0, 2, 4, 6 and 8 start engine A and iterations 1, 3, 5, 7 and 9 start engine B.
- R5: A done pulse from the running engine, sampled at edge N, makes the next start pulse visible after edge N+2.
- R6: A done pulse from the engine that is not running is ignored, and so is a done pulse while no engine is running. Neither produces a start pulse, and neither changes the timing of later start pulses.
- R7: Exactly ITERS (default 10) iterations run, counted 0 through 9. After the last done pulse, sampled at edge N, `finished_o` becomes visible after edge N+2.
- R8: `finished_o` stays high until a new `start_i` is accepted. The accepting edge clears it, and the new run begins again with engine A.
- R9: A `start_i` that arrives while a run is in progress is ignored.
- R10: The block waits for a done pulse for any number of cycles without issuing another start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a run; honoured only when idle |
| eng_a_done_i | input | 1 | Single-cycle done pulse from engine A |
| eng_b_done_i | input | 1 | Single-cycle done pulse from engine B |
| eng_a_start_o | output | 1 | Single-cycle start pulse to engine A |
| eng_b_start_o | output | 1 | Single-cycle start pulse to engine B |
| finished_o | output | 1 | High once all iterations are complete, held until the next accepted start |

## Verification
Each kind of internal fault shows up at the ports within a few cycles:

- **Wrong selector value:** an iteration's start pulse appears on the wrong engine output, two edges after the previous done.
- **Lost or duplicated predicate:** a start pulse comes at the wrong cycle, disappears, or arrives unexpectedly.
- **Off-by-one counter:** `finished_o` rises one iteration early or late, or an extra start pulse is issued.
- **Start or done accepted when it should be ignored:** a stray engine-A pulse appears three edges after the stray input.

The bench compares every pulse against an expected engine and cycle, so each of these faults shows up as a miscompare.

// File: rtl/alt_loop_seq_pkg.sv
package alt_loop_seq_pkg;
  // Predicate chain positions
  localparam int PRED_N  = 5;
  localparam int P_ENTRY = 0;
  localparam int P_SEL   = 1;
  localparam int P_WAIT  = 2;
  localparam int P_BACK  = 3;
  localparam int P_EXIT  = 4;
endpackage

// File: rtl/alt_pred_fwd.sv
// One-bit predicate register: set by the forwarding stage, optionally held.
module alt_pred_fwd (
  input  logic clk,
  input  logic rst,
  input  logic fwd_i,
  input  logic keep_i,
  output logic pred_o
);
  always_ff @(posedge clk) begin
    if (rst) pred_o <= 1'b0;
    else     pred_o <= fwd_i | (keep_i & pred_o);
  end
endmodule

// File: rtl/alt_loop_head.sv
// Loop-head decision: route the enable to exit or to engine select.
module alt_loop_head #(
  parameter int ITERS = 10,
  parameter int CNT_W = 4
) (
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             go_exit_o,
  output logic             go_sel_o
);
  logic last;
  assign last      = (cnt_i == CNT_W'(ITERS));
  assign go_exit_o = en_i & last;
  assign go_sel_o  = en_i & ~last;
endmodule

// File: rtl/alt_iter_state.sv
// Selector flag and iteration counter, reinitialised on an accepted start.
module alt_iter_state #(
  parameter int CNT_W     = 4,
  parameter bit FLAG_INIT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_i,
  input  logic             step_i,
  output logic             flag_o,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst || init_i) begin
      flag_o <= FLAG_INIT;
      cnt_o  <= '0;
    end else if (step_i) begin
      flag_o <= ~flag_o;
      cnt_o  <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/alt_loop_seq.sv
module alt_loop_seq
  import alt_loop_seq_pkg::*;
#(
  parameter int ITERS     = 10,
  parameter bit FLAG_INIT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic eng_a_done_i,
  input  logic eng_b_done_i,
  output logic eng_a_start_o,
  output logic eng_b_start_o,
  output logic finished_o
);
  localparam int CNT_W = $clog2(ITERS + 1);

  logic [PRED_N-1:0] pred_q;
  logic [PRED_N-1:0] pred_set;
  logic [PRED_N-1:0] pred_keep;
  logic              busy;
  logic              accept;
  logic              head_en;
  logic              go_sel;
  logic              go_exit;
  logic              flag;
  logic              done_run;
  logic              tail_fire;
  logic [CNT_W-1:0]  iter_cnt;

  // Any armed predicate means a run is in progress
  assign busy      = |pred_q;
  assign accept    = start_i & ~busy;
  // Head enabled by first entry or by the enable returning from the tail
  assign head_en   = pred_q[P_ENTRY] | pred_q[P_BACK];
  // Only the engine chosen by the selector may close the iteration
  assign done_run  = flag ? eng_a_done_i : eng_b_done_i;
  assign tail_fire = pred_q[P_WAIT] & done_run;

  always_comb begin
    pred_set          = '0;
    pred_keep         = '0;
    pred_set[P_ENTRY] = accept;
    pred_set[P_SEL]   = go_sel;
    pred_set[P_WAIT]  = pred_q[P_SEL];
    pred_keep[P_WAIT] = ~done_run;
    pred_set[P_BACK]  = tail_fire;
    pred_set[P_EXIT]  = go_exit;
  end

  generate
    for (genvar gi = 0; gi < PRED_N; gi++) begin : g_pred
      alt_pred_fwd u_pf (
        .clk    (clk),
        .rst    (rst),
        .fwd_i  (pred_set[gi]),
        .keep_i (pred_keep[gi]),
        .pred_o (pred_q[gi])
      );
    end
  endgenerate

  alt_loop_head #(.ITERS(ITERS), .CNT_W(CNT_W)) u_head (
    .en_i      (head_en),
    .cnt_i     (iter_cnt),
    .go_exit_o (go_exit),
    .go_sel_o  (go_sel)
  );

  alt_iter_state #(.CNT_W(CNT_W), .FLAG_INIT(FLAG_INIT)) u_state (
    .clk    (clk),
    .rst    (rst),
    .init_i (accept),
    .step_i (tail_fire),
    .flag_o (flag),
    .cnt_o  (iter_cnt)
  );

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      eng_a_start_o <= 1'b0;
      eng_b_start_o <= 1'b0;
      finished_o    <= 1'b0;
    end else begin
      eng_a_start_o <= pred_q[P_SEL] & flag;
      eng_b_start_o <= pred_q[P_SEL] & ~flag;
      if (accept)              finished_o <= 1'b0;
      else if (pred_q[P_EXIT]) finished_o <= 1'b1;
    end
  end
endmodule

// File: rtl/alt_loop_seq_chk.sv
module alt_loop_seq_chk
  import alt_loop_seq_pkg::*;
#(
  parameter int ITERS = 10
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           start_i,
  input logic                           eng_a_start_o,
  input logic                           eng_b_start_o,
  input logic                           finished_o,
  input logic [PRED_N-1:0]              pred_q,
  input logic [$clog2(ITERS + 1)-1:0]   iter_cnt
);
  localparam int CNT_W = $clog2(ITERS + 1);

  a_r3_excl_starts: assert property (@(posedge clk) disable iff (rst)
    !(eng_a_start_o && eng_b_start_o));

  a_r3_a_single: assert property (@(posedge clk) disable iff (rst)
    eng_a_start_o |=> !eng_a_start_o);

  a_r3_b_single: assert property (@(posedge clk) disable iff (rst)
    eng_b_start_o |=> !eng_b_start_o);

  a_r9_one_stage: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pred_q));

  a_r9_launch_busy: assert property (@(posedge clk) disable iff (rst)
    (eng_a_start_o || eng_b_start_o) |-> (pred_q != '0));

  a_r8_fin_hold: assert property (@(posedge clk) disable iff (rst)
    (finished_o && !start_i) |=> finished_o);

  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    iter_cnt <= CNT_W'(ITERS));

  a_r7_fin_count: assert property (@(posedge clk) disable iff (rst)
    $rose(finished_o) |-> (iter_cnt == CNT_W'(ITERS)));
endmodule

bind alt_loop_seq alt_loop_seq_chk #(.ITERS(ITERS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .start_i       (start_i),
  .eng_a_start_o (eng_a_start_o),
  .eng_b_start_o (eng_b_start_o),
  .finished_o    (finished_o),
  .pred_q        (pred_q),
  .iter_cnt      (iter_cnt)
);

// File: tb/test_alt_loop_seq.sv
`timescale 1ns/1ps
module test_alt_loop_seq;
  localparam int ITERS = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic eng_a_done_i = 1'b0;
  logic eng_b_done_i = 1'b0;
  logic eng_a_start_o;
  logic eng_b_start_o;
  logic finished_o;

  alt_loop_seq #(.ITERS(ITERS)) i_alt_loop_seq (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .eng_a_done_i  (eng_a_done_i),
    .eng_b_done_i  (eng_b_done_i),
    .eng_a_start_o (eng_a_start_o),
    .eng_b_start_o (eng_b_start_o),
    .finished_o    (finished_o)
  );

  always #4 clk = ~clk;  // 125 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Event codes: 1 = start engine A, 2 = start engine B, 3 = finished rises
  typedef struct {int code; int at;} ev_t;
  ev_t expq[$];

  int  n_chk = 0;
  int  n_fail = 0;
  bit  mon_on = 1'b0;
  bit  fin_prev = 1'b0;
  bit  all_done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic take(input int code);
    ev_t e;
    if (expq.size() == 0) begin
      chk(1'b0, "R6 or R9", "unexpected output event code", code, 0);
    end else begin
      e = expq.pop_front();
      chk(e.code == code, (code == 3) ? "R7" : "R4", "event kind", code, e.code);
      chk(e.at == cyc, "R5 R10", "event cycle", cyc, e.at);
    end
  endtask

  // Monitor: pops the scoreboard as outputs appear
  always @(negedge clk) begin
    if (mon_on) begin
      if (eng_a_start_o) take(1);
      if (eng_b_start_o) take(2);
      if (finished_o && !fin_prev) take(3);
      fin_prev = finished_o;
      while (expq.size() > 0 && expq[0].at < cyc) begin
        chk(1'b0, "R7", "missing event code", 0, expq[0].code);
        void'(expq.pop_front());
      end
    end
  end

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Driver: one full run; expected events pushed from timing rules
  task automatic run_seq(input int gap, input bit noise, input int long_it);
    int s;
    int d;
    int u;
    bit use_a;
    start_i = 1'b1;
    s = cyc + 3;
    expq.push_back('{1, s});
    @(negedge clk);
    start_i = 1'b0;
    chk(finished_o == 1'b0, "R8", "finished cleared by accepted start", finished_o, 0);
    wait_until(s - 1);
    chk(eng_a_start_o == 1'b0, "R2", "no start one edge early", eng_a_start_o, 0);
    for (int k = 0; k < ITERS; k++) begin
      use_a = (k % 2 == 0);
      wait_until(s);
      d = gap + (k % 3);
      if (d < 1) d = 1;
      if (k == long_it) d = 40;
      @(negedge clk);
      chk(!eng_a_start_o && !eng_b_start_o, "R3", "start pulse one cycle",
          int'(eng_a_start_o) + int'(eng_b_start_o), 0);
      if (noise && d >= 3) begin
        // wrong-engine done and a start while busy: both must be ignored
        if (use_a) eng_b_done_i = 1'b1; else eng_a_done_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        eng_a_done_i = 1'b0;
        eng_b_done_i = 1'b0;
        start_i = 1'b0;
      end
      wait_until(s + d);
      if (use_a) eng_a_done_i = 1'b1; else eng_b_done_i = 1'b1;
      u = cyc;
      if (k < ITERS - 1) expq.push_back('{use_a ? 2 : 1, u + 3});
      else               expq.push_back('{3, u + 3});
      @(negedge clk);
      eng_a_done_i = 1'b0;
      eng_b_done_i = 1'b0;
      s = u + 3;
    end
    wait_until(s);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(!eng_a_start_o && !eng_b_start_o && !finished_o, "R1", "outputs during reset",
        int'(eng_a_start_o) + int'(eng_b_start_o) + int'(finished_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!eng_a_start_o && !eng_b_start_o && !finished_o, "R1", "outputs after reset",
        int'(eng_a_start_o) + int'(eng_b_start_o) + int'(finished_o), 0);
    mon_on = 1'b1;
    // stray done while idle (R6)
    eng_a_done_i = 1'b1;
    @(negedge clk);
    eng_a_done_i = 1'b0;
    repeat (5) @(negedge clk);
    chk(finished_o == 1'b0, "R6", "idle done leaves finished low", finished_o, 0);

    run_seq(0, 1'b0, -1);
    // finished holds, stray done ignored (R8, R6)
    eng_b_done_i = 1'b1;
    @(negedge clk);
    eng_b_done_i = 1'b0;
    for (int i = 0; i < 10; i++) begin
      chk(finished_o == 1'b1, "R8", "finished held", finished_o, 1);
      @(negedge clk);
    end

    run_seq(3, 1'b1, 4);
    repeat (3) @(negedge clk);
    run_seq(1, 1'b0, 7);
    repeat (6) @(negedge clk);
    chk(expq.size() == 0, "R7", "scoreboard drained", expq.size(), 0);
    chk(finished_o == 1'b1, "R8", "finished held at end", finished_o, 1);
    all_done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!all_done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog expired: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule